// File: doc/BRIEF.md
# Interrupt Flag and Sense Controller

This block collects interrupt events from a small set of external pins and from one timer overflow pulse. It keeps a pending flag for each source and presents a gated request per source to the CPU sequencer. Each pin has its own 2-bit sense field. The field selects low-level, falling-edge or rising-edge triggering. Pin inputs pass through a two-flop synchroniser before edge detection. A pin driven by the chip itself still triggers, so software can raise an interrupt by writing the pin.

When the sequencer takes a vector, it pulses a single acknowledge. The block then clears the flag of the highest-priority source that is requesting. Pins come first in index order, and the overflow source comes last. Software may also clear any flag by writing a one to its bit in the clear strobe. In low-level mode no flag is latched: the source requests for as long as the synchronised pin stays low.

Top module: `irq_sense_ctrl`

## Requirements
- R1: After a synchronous reset, all flags, requests and the priority select are zero.
- R2: A one-cycle pulse on `tmr_ovf` sets the overflow flag (bit 2 of `flag_q`) at the next clock edge.
- R3: With sense code 2'b10 (falling edge), a high-to-low pin transition sets that pin's flag at the third clock edge after the change. Sense field of pin i is `sense_cfg[2i+1:2i]`; flag bit i belongs to pin i.
- R4: With sense code 2'b11 (rising edge), a low-to-high transition sets the flag at the third edge, and a high-to-low transition sets nothing.
- R5: With sense code 2'b00 (low level), the pin's request is asserted while the synchronised pin is low, without setting its flag. The request drops at the second edge after the pin returns high.
- R6: Sense code 2'b01 is reserved: pin transitions in either direction set no flag and raise no request.
- R7: `irq_req[i]` is one only when `glb_en`, `src_en[i]` and source i's pending state are all one. Clearing an enable does not clear the flag.
- R8: A one in `clr_wr[i]` clears flag i at the next edge. A zero leaves the flag unchanged.
- R9: `irq_sel` is one-hot on the lowest-indexed active request (pin 0, then pin 1, then overflow), or zero if none. `vec_ack` clears only that selected flag.
- R10: If a set event and a clear (software or acknowledge) hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 2 | Asynchronous external interrupt pins |
| tmr_ovf | input | 1 | Timer overflow pulse, one cycle per event |
| sense_cfg | input | 4 | Sense code per pin, two bits each |
| src_en | input | 3 | Per-source enable (pin0, pin1, overflow) |
| glb_en | input | 1 | Global interrupt enable |
| clr_wr | input | 3 | Write-one-to-clear strobe per flag |
| vec_ack | input | 1 | Vector taken; clears the selected flag |
| flag_q | output | 3 | Pending flags |
| irq_req | output | 3 | Gated requests per source |
| irq_sel | output | 3 | One-hot highest-priority request |

## Verification
A corrupted synchroniser or edge-history register shows up as a flag that sets one edge early or late, or as a flag set on the wrong transition direction. Either is visible on `flag_q` within three cycles of the pin change. A flag register that misses a clear or a set shows on `flag_q` at the next edge. Because `irq_req` and `irq_sel` follow the flags combinationally, the same error shows on those outputs in the same cycle. A wrong priority choice shows at once on `irq_sel`, and one cycle later as the wrong flag dropping after `vec_ack`.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int SENSE_W = 2;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_RSVD = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    // Edge-mode trigger decision for one pin
    function automatic logic edge_trigger(input sense_e mode, input logic rose, input logic fell);
        case (mode)
            SENSE_FALL: edge_trigger = fell;
            SENSE_RISE: edge_trigger = rose;
            default:    edge_trigger = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irq_pin_sense.sv
module irq_pin_sense
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_i,
    input  sense_e mode_i,
    output logic   set_o,
    output logic   lvl_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= cur;
        end
    end

    assign set_o = edge_trigger(mode_i, cur & ~prev_q, ~cur & prev_q);
    assign lvl_o = (mode_i == SENSE_LOW) && !cur;

    // R3
    fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (set_o && mode_i == SENSE_FALL) |-> (!cur && prev_q));

endmodule

// File: rtl/irq_flag.sv
module irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q);

    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N = 3
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] sel_o
);
    always_comb begin
        sel_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) sel_o = N'(1) << i;
        end
    end

    // R9
    sel_onehot_chk: assert final ($onehot0(sel_o));

endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_PINS    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_SRC    = NUM_PINS + 1,
    localparam int CFG_W      = NUM_PINS * SENSE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_PINS-1:0] ext_pin,
    input  logic               tmr_ovf,
    input  logic [CFG_W-1:0]   sense_cfg,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               glb_en,
    input  logic [NUM_SRC-1:0] clr_wr,
    input  logic               vec_ack,
    output logic [NUM_SRC-1:0] flag_q,
    output logic [NUM_SRC-1:0] irq_req,
    output logic [NUM_SRC-1:0] irq_sel
);
    logic [NUM_SRC-1:0] set_v;
    logic [NUM_SRC-1:0] lvl_v;
    logic [NUM_SRC-1:0] clr_v;
    logic [NUM_SRC-1:0] pend_v;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        irq_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) i_sense (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (ext_pin[i]),
            .mode_i (sense_e'(sense_cfg[SENSE_W*i +: SENSE_W])),
            .set_o  (set_v[i]),
            .lvl_o  (lvl_v[i])
        );
    end

    assign set_v[NUM_SRC-1] = tmr_ovf;
    assign lvl_v[NUM_SRC-1] = 1'b0;

    assign clr_v = clr_wr | ({NUM_SRC{vec_ack}} & irq_sel);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
        irq_flag i_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[s]),
            .clr_i  (clr_v[s]),
            .flag_q (flag_q[s])
        );
    end

    assign pend_v  = flag_q | lvl_v;
    assign irq_req = {NUM_SRC{glb_en}} & src_en & pend_v;

    irq_prio #(.N(NUM_SRC)) i_prio (
        .req_i (irq_req),
        .sel_o (irq_sel)
    );

    // R2
    ovf_sets_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf |=> flag_q[NUM_SRC-1]);

    // R9
    ack_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_ack && irq_sel[0] && !set_v[0]) |=> !flag_q[0]);

endmodule

// File: tb/test_irq_sense_ctrl.sv
module test_irq_sense_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] ext_pin;
    logic       tmr_ovf;
    logic [3:0] sense_cfg;
    logic [2:0] src_en;
    logic       glb_en;
    logic [2:0] clr_wr;
    logic       vec_ack;
    logic [2:0] flag_q;
    logic [2:0] irq_req;
    logic [2:0] irq_sel;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_sense_ctrl i_irq_sense_ctrl (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
        .sense_cfg(sense_cfg), .src_en(src_en), .glb_en(glb_en),
        .clr_wr(clr_wr), .vec_ack(vec_ack),
        .flag_q(flag_q), .irq_req(irq_req), .irq_sel(irq_sel)
    );

    typedef struct packed {
        logic [1:0] pins;
        logic       ovf;
        logic [2:0] clr;
        logic       ack;
        logic [2:0] en;
        logic       gie;
        logic [2:0] ef;
        logic [2:0] er;
        logic [2:0] es;
    } step_t;

    localparam int NSTEP = 17;
    // pin0 falling-edge mode, pin1 rising-edge mode during the table
    localparam step_t TBL [NSTEP] = '{
        '{2'b01, 1'b0, 3'b000, 1'b0, 3'b111, 1'b1, 3'b000, 3'b000, 3'b000},
        '{2'b01, 1'b1, 3'b000, 1'b0, 3'b111, 1'b1, 3'b000, 3'b000, 3'b000},
        '{2'b01, 1'b0, 3'b000, 1'b0, 3'b111, 1'b1, 3'b100, 3'b100, 3'b100},
        '{2'b00, 1'b0, 3'b000, 1'b0, 3'b111, 1'b1, 3'b100, 3'b100, 3'b100},
        '{2'b00, 1'b0, 3'b000, 1'b0, 3'b111, 1'b1, 3'b100, 3'b100, 3'b100},
        '{2'b00, 1'b0, 3'b000, 1'b0, 3'b111, 1'b1, 3'b100, 3'b100, 3'b100},
        '{2'b00, 1'b0, 3'b000, 1'b0, 3'b111, 1'b1, 3'b101, 3'b101, 3'b001},
        '{2'b00, 1'b0, 3'b000, 1'b1, 3'b111, 1'b1, 3'b101, 3'b101, 3'b001},
        '{2'b10, 1'b0, 3'b000, 1'b0, 3'b111, 1'b1, 3'b100, 3'b100, 3'b100},
        '{2'b10, 1'b0, 3'b000, 1'b0, 3'b111, 1'b1, 3'b100, 3'b100, 3'b100},
        '{2'b10, 1'b0, 3'b000, 1'b0, 3'b111, 1'b1, 3'b100, 3'b100, 3'b100},
        '{2'b10, 1'b0, 3'b000, 1'b0, 3'b111, 1'b1, 3'b110, 3'b110, 3'b010},
        '{2'b10, 1'b0, 3'b000, 1'b0, 3'b101, 1'b1, 3'b110, 3'b100, 3'b100},
        '{2'b10, 1'b0, 3'b000, 1'b0, 3'b111, 1'b0, 3'b110, 3'b000, 3'b000},
        '{2'b10, 1'b0, 3'b010, 1'b0, 3'b111, 1'b1, 3'b110, 3'b110, 3'b010},
        '{2'b10, 1'b0, 3'b000, 1'b1, 3'b111, 1'b1, 3'b100, 3'b100, 3'b100},
        '{2'b10, 1'b0, 3'b000, 1'b0, 3'b111, 1'b1, 3'b000, 3'b000, 3'b000}
    };

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; ext_pin = 2'b01; tmr_ovf = 1'b0; sense_cfg = 4'b1110;
        src_en = 3'b111; glb_en = 1'b1; clr_wr = 3'b000; vec_ack = 1'b0;
        @(negedge clk);
        cyc(3);
        // R1 reset state
        check("R1 flags", flag_q, 3'b000);
        check("R1 req", irq_req, 3'b000);
        check("R1 sel", irq_sel, 3'b000);
        rst = 1'b0;

        // Table: R2 ovf, R3 falling, R4 rising, R7 gating, R8 w1c, R9 priority/ack
        for (int s = 0; s < NSTEP; s++) begin
            ext_pin = TBL[s].pins; tmr_ovf = TBL[s].ovf; clr_wr = TBL[s].clr;
            vec_ack = TBL[s].ack; src_en = TBL[s].en; glb_en = TBL[s].gie;
            #1;
            check($sformatf("R2/R3/R4/R8 flags step %0d", s), flag_q, TBL[s].ef);
            check($sformatf("R7 req step %0d", s), irq_req, TBL[s].er);
            check($sformatf("R9 sel step %0d", s), irq_sel, TBL[s].es);
            @(posedge clk);
            @(negedge clk);
        end
        tmr_ovf = 1'b0; clr_wr = 3'b000; vec_ack = 1'b0;

        // R5 low-level mode on pin0 (pin0 is low already)
        sense_cfg = 4'b1100;
        #1;
        check("R5 level req while low", irq_req, 3'b001);
        check("R5 no flag latched", flag_q, 3'b000);
        ext_pin = 2'b11;
        cyc(1);
        check("R5 req held one edge", irq_req, 3'b001);
        cyc(1);
        check("R5 req dropped", irq_req, 3'b000);

        // R6 reserved code ignores both directions
        sense_cfg = 4'b1101;
        ext_pin = 2'b10;
        cyc(4);
        check("R6 fall ignored flags", flag_q, 3'b000);
        check("R6 fall ignored req", irq_req, 3'b000);
        ext_pin = 2'b11;
        cyc(4);
        check("R6 rise ignored", flag_q, 3'b000);

        // R4 rising mode ignores a falling edge on pin1
        sense_cfg = 4'b1110;
        ext_pin = 2'b01;
        cyc(4);
        check("R4 fall ignored in rise mode", flag_q, 3'b000);

        // R10 set wins over software clear on the overflow flag
        tmr_ovf = 1'b1;
        cyc(1);
        check("R10 pre-set", flag_q, 3'b100);
        clr_wr = 3'b100;
        cyc(1);
        tmr_ovf = 1'b0; clr_wr = 3'b000;
        check("R10 set beats clear", flag_q, 3'b100);

        // R10 set wins over acknowledge (overflow selected)
        tmr_ovf = 1'b1; vec_ack = 1'b1;
        cyc(1);
        tmr_ovf = 1'b0; vec_ack = 1'b0;
        check("R10 set beats ack", flag_q, 3'b100);

        // R8 zero write leaves the flag
        clr_wr = 3'b011;
        cyc(1);
        clr_wr = 3'b000;
        check("R8 zero bit keeps flag", flag_q, 3'b100);

        // R1 reset mid-run clears state
        rst = 1'b1;
        cyc(1);
        rst = 1'b0;
        check("R1 reset clears flags", flag_q, 3'b000);
        check("R1 reset clears req", irq_req, 3'b000);

        finish_run();
    end

endmodule